// File: doc/BRIEF.md
# SDR SDRAM Power-Up Sequencer

This block brings an SDR SDRAM device from power-on to a usable state and then hands the command bus to the normal access controller. After reset it waits through a long settling period with the clock-enable pin low. It raises clock-enable partway through that wait. It then closes every bank, runs two auto-refresh cycles with recovery gaps between them, and programs the mode register with a fixed operating word. Each command occupies one cycle, and the cycles between commands carry NOP. When the sequence ends, `init_done` rises and stays high.

A single down-counter times the whole sequence, and each command is tied to a fixed counter value. The startup length and each command slot are parameters. The defaults give about 100 µs of settling at 100 MHz. A synchronous `restart` input runs the sequence again from the beginning. A small refresh gate sits on the handover side. It ignores refresh requests that arrive before `init_done`, so the access controller starts with no refresh owed.

Top module: `sdram_powerup_seq`

## Requirements
- R1: While `rst_n` is low: `cke` is 0, `cmd` is NOP (4'b0111), `addr` is 0, `ba` is 0, and `init_done` and `refresh_pending` are 0.
- R2: `cke` stays 0 until the counter reaches `CKE_AT` (default 100) and stays 1 after that. While `cke` is 0, `cmd` is NOP. At least one NOP with `cke` high comes before the first other command.
- R3: At counter value `PRE_AT` (default 21) the block issues precharge-all: `cmd` = 4'b0010 and `addr` = 13'h0400 (bit 10 set, all other bits 0).
- R4: At counter values `REF1_AT` (18) and `REF2_AT` (11) the block issues auto-refresh: `cmd` = 4'b0001 and `addr` = 0. NOPs follow each one.
- R5: At counter value `LMR_AT` (4) the block issues load-mode: `cmd` = 4'b0000 and `addr` = 13'h0021. Bits 2:0 = 001 (burst of 2), bit 3 = 0 (sequential), bits 6:4 = 010 (CAS latency 2), bits 8:7 = 00 (standard mode), bit 9 = 0 (burst writes).
- R6: In every other cycle `cmd` is NOP with `addr` = 0. `ba` is 0 in every cycle.
- R7: `init_done` rises when the counter reaches 0 and stays high until the next reset or restart.
- R8: When `restart` is high at a clock edge, the next outputs are: `cke` = 0, `cmd` = NOP, `addr` = 0, `init_done` = 0 and `refresh_pending` = 0. The full sequence then runs again from `START_CYCLES`.
- R9: A `refresh_req` that arrives while `init_done` is 0 is discarded. `refresh_pending` stays 0 through the whole sequence and at handover.
- R10: Once `init_done` is 1, `refresh_req` sets `refresh_pending` at the next edge. It stays set until `refresh_grant` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low reset: asserts asynchronously, released synchronous to `clk` |
| restart | input | 1 | Synchronous request to rerun the power-up sequence |
| refresh_req | input | 1 | Periodic refresh tick from the refresh timer |
| refresh_grant | input | 1 | Pulse from the access controller when it issues the owed refresh |
| cke | output | 1 | SDRAM clock enable |
| cmd | output | 4 | {cs_n, ras_n, cas_n, we_n} command code |
| addr | output | 13 | SDRAM address bus |
| ba | output | 2 | SDRAM bank address |
| init_done | output | 1 | Sequence complete; the access controller owns the bus |
| refresh_pending | output | 1 | A refresh is owed to the device |

## Verification
The counter holds `START_CYCLES` at the first edge after reset or restart. It loses one at each following edge, and every output is registered once. A command slotted at counter value c therefore appears just after edge `START_CYCLES - c + 1`, and `init_done` appears after edge `START_CYCLES + 1`. The bench numbers edges from the release of reset or restart. At each falling edge it derives c from the edge number and compares every output with the value that c calls for. Refresh requests and grants are driven at a falling edge. Their effect on `refresh_pending` is read at the falling edge that follows the next rising edge.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // Command code {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_LOADMODE = 4'b0000;
  localparam logic [3:0] CMD_AUTOREF  = 4'b0001;
  localparam logic [3:0] CMD_PRECHG   = 4'b0010;
  localparam logic [3:0] CMD_NOP      = 4'b0111;

  localparam int ADDR_W = 13;
  localparam int BANK_W = 2;
  localparam int CMD_W  = 4;

  // Address bit that widens a precharge to every bank
  localparam int ALL_BANKS_BIT = 10;

  // Mode word: burst writes, standard mode, CAS 2, sequential, burst length 2
  localparam logic [ADDR_W-1:0] MODE_WORD =
    {3'b000, 1'b0, 2'b00, 3'b010, 1'b0, 3'b001};

  typedef struct packed {
    logic [CMD_W-1:0]  cmd;
    logic [ADDR_W-1:0] addr;
    logic [BANK_W-1:0] ba;
  } bus_word_t;

endpackage

// File: rtl/init_countdown.sv
module init_countdown #(
  parameter int START_CYCLES = 10100,
  parameter int CNT_W        = $clog2(START_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  output logic [CNT_W-1:0] count,
  output logic             at_zero
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign at_zero = (cnt_q == '0);
  assign cnt_en  = restart | ~at_zero;

  always_comb begin
    cnt_d = cnt_q;
    if (restart)      cnt_d = CNT_W'(START_CYCLES);
    else if (!at_zero) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CNT_W'(START_CYCLES);
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

endmodule

// File: rtl/init_slot_decode.sv
module init_slot_decode
  import sdram_init_pkg::*;
#(
  parameter int CNT_W   = 14,
  parameter int CKE_AT  = 100,
  parameter int PRE_AT  = 21,
  parameter int REF1_AT = 18,
  parameter int REF2_AT = 11,
  parameter int LMR_AT  = 4
) (
  input  logic [CNT_W-1:0] count,
  output bus_word_t        word,
  output logic             cke_on
);

  localparam int NSLOT = 4;
  localparam int SLOT_AT [NSLOT] = '{PRE_AT, REF1_AT, REF2_AT, LMR_AT};

  logic [NSLOT-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < NSLOT; g++) begin : g_slot
      assign hit[g] = (count == CNT_W'(SLOT_AT[g]));
    end
  endgenerate

  assign cke_on = (count <= CNT_W'(CKE_AT));

  always_comb begin
    word.cmd  = CMD_NOP;
    word.addr = '0;
    word.ba   = '0;
    if (hit[0]) begin
      word.cmd                 = CMD_PRECHG;
      word.addr[ALL_BANKS_BIT] = 1'b1;
    end else if (hit[1] || hit[2]) begin
      word.cmd = CMD_AUTOREF;
    end else if (hit[3]) begin
      word.cmd  = CMD_LOADMODE;
      word.addr = MODE_WORD;
    end
  end

endmodule

// File: rtl/refresh_gate.sv
module refresh_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic ready,
  input  logic req,
  input  logic grant,
  output logic pending
);

  logic pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (restart || !ready) pend_d = 1'b0;
    else if (req)          pend_d = 1'b1;
    else if (grant)        pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pending = pend_q;

endmodule

// File: rtl/sdram_powerup_seq.sv
module sdram_powerup_seq
  import sdram_init_pkg::*;
#(
  parameter int START_CYCLES = 10100,
  parameter int CKE_AT       = 100,
  parameter int PRE_AT       = 21,
  parameter int REF1_AT      = 18,
  parameter int REF2_AT      = 11,
  parameter int LMR_AT       = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        restart,
  input  logic        refresh_req,
  input  logic        refresh_grant,
  output logic        cke,
  output logic [3:0]  cmd,
  output logic [12:0] addr,
  output logic [1:0]  ba,
  output logic        init_done,
  output logic        refresh_pending
);

  localparam int CNT_W = $clog2(START_CYCLES + 1);

  logic [CNT_W-1:0] count;
  logic             at_zero;
  bus_word_t        slot_word;
  logic             cke_on;

  bus_word_t bus_q, bus_d;
  logic      cke_q, cke_d;
  logic      done_q, done_d;

  init_countdown #(
    .START_CYCLES(START_CYCLES),
    .CNT_W       (CNT_W)
  ) u_count (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(restart),
    .count  (count),
    .at_zero(at_zero)
  );

  init_slot_decode #(
    .CNT_W  (CNT_W),
    .CKE_AT (CKE_AT),
    .PRE_AT (PRE_AT),
    .REF1_AT(REF1_AT),
    .REF2_AT(REF2_AT),
    .LMR_AT (LMR_AT)
  ) u_slots (
    .count (count),
    .word  (slot_word),
    .cke_on(cke_on)
  );

  always_comb begin
    bus_d  = slot_word;
    cke_d  = cke_on;
    done_d = at_zero;
    if (restart) begin
      bus_d.cmd  = CMD_NOP;
      bus_d.addr = '0;
      bus_d.ba   = '0;
      cke_d      = 1'b0;
      done_d     = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_q.cmd  <= CMD_NOP;
      bus_q.addr <= '0;
      bus_q.ba   <= '0;
      cke_q      <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      bus_q  <= bus_d;
      cke_q  <= cke_d;
      done_q <= done_d;
    end
  end

  refresh_gate u_refgate (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(restart),
    .ready  (done_q),
    .req    (refresh_req),
    .grant  (refresh_grant),
    .pending(refresh_pending)
  );

  assign cke       = cke_q;
  assign cmd       = bus_q.cmd;
  assign addr      = bus_q.addr;
  assign ba        = bus_q.ba;
  assign init_done = done_q;

endmodule

// File: rtl/sdram_powerup_seq_chk.sv
module sdram_powerup_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        restart,
  input logic        cke,
  input logic [3:0]  cmd,
  input logic [12:0] addr,
  input logic [1:0]  ba,
  input logic        init_done,
  input logic        refresh_pending
);

  // R2: only NOP while clock enable is low
  a_r2_nop_while_cke_low: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> cmd == 4'b0111);

  // R2: a real command needs cke high in this cycle and the one before
  a_r2_nop_before_command: assert property (@(posedge clk) disable iff (!rst_n)
    cmd != 4'b0111 |-> cke && $past(cke));

  // R3: precharge always targets every bank
  a_r3_precharge_all: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 4'b0010 |-> addr == 13'h0400);

  // R4: a refresh is followed by NOPs
  a_r4_refresh_recovery: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 4'b0001 |=> cmd == 4'b0111);

  // R5: load-mode carries the fixed mode word
  a_r5_mode_word: assert property (@(posedge clk) disable iff (!rst_n)
    cmd == 4'b0000 |-> addr == 13'h0021);

  // R6: bank outputs are 0 throughout
  a_r6_bank_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ba == 2'b00);

  // R7: done holds until a restart
  a_r7_done_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    init_done && !restart |=> init_done);

  // R8: restart drops done and cke
  a_r8_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !init_done && !cke && !refresh_pending);

  // R9: nothing pending before handover
  a_r9_no_pending_early: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !refresh_pending);

endmodule

bind sdram_powerup_seq sdram_powerup_seq_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .restart        (restart),
  .cke            (cke),
  .cmd            (cmd),
  .addr           (addr),
  .ba             (ba),
  .init_done      (init_done),
  .refresh_pending(refresh_pending)
);

// File: tb/sdram_powerup_seq_tb.sv
module sdram_powerup_seq_tb;

  localparam int START = 10100;
  localparam int CKE_AT = 100;
  localparam int PRE_AT = 21;
  localparam int REF1_AT = 18;
  localparam int REF2_AT = 11;
  localparam int LMR_AT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        restart = 1'b0;
  logic        refresh_req = 1'b0;
  logic        refresh_grant = 1'b0;
  logic        cke;
  logic [3:0]  cmd;
  logic [12:0] addr;
  logic [1:0]  ba;
  logic        init_done;
  logic        refresh_pending;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  sdram_powerup_seq u_dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .restart        (restart),
    .refresh_req    (refresh_req),
    .refresh_grant  (refresh_grant),
    .cke            (cke),
    .cmd            (cmd),
    .addr           (addr),
    .ba             (ba),
    .init_done      (init_done),
    .refresh_pending(refresh_pending)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  // Walks n edges after a reset release or restart edge; edge k sees count START-(k-1)
  task automatic run_sequence(input int n_edges, input bit req_during);
    for (int k = 1; k <= n_edges; k++) begin
      int c;
      logic [3:0]  e_cmd;
      logic [12:0] e_addr;
      string tag;
      step();
      c = START - (k - 1);
      if (c < 0) c = 0;
      e_cmd = 4'b0111; e_addr = 13'h0; tag = "R6";
      if (c == PRE_AT) begin e_cmd = 4'b0010; e_addr = 13'h0400; tag = "R3"; end
      else if (c == REF1_AT || c == REF2_AT) begin e_cmd = 4'b0001; tag = "R4"; end
      else if (c == LMR_AT) begin e_cmd = 4'b0000; e_addr = 13'h0021; tag = "R5"; end
      chk({tag, " cmd"}, 32'(cmd), 32'(e_cmd));
      chk({tag, " addr"}, 32'(addr), 32'(e_addr));
      chk("R6 ba", 32'(ba), 32'h0);
      chk("R2 cke", 32'(cke), 32'(c <= CKE_AT));
      chk("R7 done", 32'(init_done), 32'(c == 0));
      chk("R9 pending", 32'(refresh_pending), 32'h0);
      refresh_req = req_during && (k >= START - 30) && (k <= START);
    end
    refresh_req = 1'b0;
  endtask

  task automatic test_reset_state;
    step();
    chk("R1 cke", 32'(cke), 32'h0);
    chk("R1 cmd", 32'(cmd), 32'h7);
    chk("R1 addr", 32'(addr), 32'h0);
    chk("R1 ba", 32'(ba), 32'h0);
    chk("R1 done", 32'(init_done), 32'h0);
    chk("R1 pending", 32'(refresh_pending), 32'h0);
  endtask

  task automatic test_first_sequence;
    rst_n = 1'b1;
    run_sequence(START + 3, 1'b1);
  endtask

  task automatic test_refresh_handshake;
    refresh_req = 1'b1;
    step();
    refresh_req = 1'b0;
    chk("R10 set", 32'(refresh_pending), 32'h1);
    step(); step(); step();
    chk("R10 held", 32'(refresh_pending), 32'h1);
    refresh_grant = 1'b1;
    step();
    refresh_grant = 1'b0;
    chk("R10 cleared", 32'(refresh_pending), 32'h0);
    chk("R7 done held", 32'(init_done), 32'h1);
  endtask

  task automatic do_restart;
    restart = 1'b1;
    step();
    restart = 1'b0;
    chk("R8 done", 32'(init_done), 32'h0);
    chk("R8 cke", 32'(cke), 32'h0);
    chk("R8 cmd", 32'(cmd), 32'h7);
    chk("R8 addr", 32'(addr), 32'h0);
    chk("R8 pending", 32'(refresh_pending), 32'h0);
  endtask

  task automatic test_restart_after_done;
    refresh_req = 1'b1;
    step();
    refresh_req = 1'b0;
    chk("R10 set before restart", 32'(refresh_pending), 32'h1);
    do_restart();
    run_sequence(START + 3, 1'b0);
  endtask

  task automatic test_restart_mid_sequence;
    do_restart();
    run_sequence(START - 14, 1'b0);
    do_restart();
    run_sequence(START + 3, 1'b0);
  endtask

  bit finished = 1'b0;

  initial begin
    test_reset_state();
    test_first_sequence();
    test_refresh_handshake();
    test_restart_after_done();
    test_restart_mid_sequence();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule